// File: doc/BRIEF.md
# Majority-Vote Serial Frame Receiver

This block pulls 8-bit asynchronous frames off a serial line. A frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. The line passes through a two-flop synchronizer and its idle level is high. The receiver runs on an oversampling tick at sixteen times the bit rate. It opens a frame on the first tick that shows a high-to-low step. It then decides each bit by a two-of-three vote over the samples taken on the 7th, 8th and 9th tick states of that bit.

Received bits move into a nine-bit register that is preloaded with all ones. The frame is complete when the start bit reaches the top position of that register. The stop bit is then shifted in one last time, and at that moment an acceptance rule decides whether the frame is published or lost. The rule uses the sticky receive-done flag and a multiprocessor mode input. A published frame sets the flag, and the flag stays set until the host pulses the clear input.

Top module: `uart_vote_rx`

## Requirements
- R1: While reset is held low on a clock edge, rx_done, rx_byte and rx_stop all read 0 after that edge.
- R2: With the line idle high, a tick that sees the synchronized line low after a high sample is tick state 0 of the start bit. Each bit lasts 16 ticks. Data arrives least significant bit first, and the first data bit lands in rx_byte bit 0.
- R3: Each bit value is the majority of the line samples at tick states 7, 8 and 9 of that bit. One disagreeing sample does not change the bit, and two disagreeing samples do.
- R4: If the start bit votes 1, the frame is abandoned without touching rx_done, rx_byte or rx_stop.
- R5: When a frame is accepted, rx_byte takes the data, rx_stop takes the voted stop bit and rx_done goes to 1. This happens at the clock edge of the stop bit's state-9 tick.
- R6: A frame that completes while rx_done is 1 is dropped, and rx_byte and rx_stop keep their values.
- R7: With mp_mode at 1, a frame whose stop bit votes 0 is dropped. With mp_mode at 0, such a frame is accepted and rx_stop reads 0.
- R8: rx_done stays 1 until flag_clr is high on a clock edge, and it reads 0 after that edge.
- R9: After the final shift, whether the frame was kept or not, and after an abandoned start, the receiver looks for the next falling edge. A frame that follows at once is received.
- R10: Outputs change only on clock edges where tick16 is high, except for the clear of rx_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| mp_mode | input | 1 | Multiprocessor mode: accept only frames whose stop bit is 1 |
| flag_clr | input | 1 | Clears rx_done |
| rx_byte | output | 8 | Last accepted data byte |
| rx_stop | output | 1 | Stop bit of the last accepted frame |
| rx_done | output | 1 | Sticky frame-received flag |

## Verification
On every cycle the assertions check the reset values, that rx_done holds its value with rx_byte and rx_stop stable, the clear action, that rx_done rises only from an internal accept, that nothing moves without a tick, and that in multiprocessor mode a frame can only be published with a stop bit of 1. Only the bench's scenarios can show the sampling position, the majority vote under one or two bad samples, rejection of a false start, data bit order, and reception of a frame that follows a dropped or abandoned one. These depend on the waveform on the line rather than on any single cycle.

// File: rtl/rxv_pkg.sv
// Package: shared types and helpers for the majority-vote receiver.
// Assumes: nothing beyond standard SystemVerilog.
package rxv_pkg;

    // Receiver states: waiting for a start edge, or shifting a frame.
    typedef enum logic {
        RX_HUNT  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_t;

    // Two-of-three majority.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxv_sync.sv
// Module: multi-stage synchronizer for the serial line.
// Assumes: the input is asynchronous and idle high, so every stage resets to 1.
module rxv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw line.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                // Later stages pass the value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxv_bitcnt.sv
// Module: divide-by-OVS bit-time counter.
// Assumes: the restart tick is state 0, so the counter loads 1 on it and
// then advances once per tick while a frame is running, wrapping at OVS.
module rxv_bitcnt #(
    parameter int OVS = 16,
    localparam int CW = $clog2(OVS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic          run,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    // Advance the bit-time phase on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CW'(1);
        end else if (run && tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rxv_voter.sv
// Module: three-sample majority bit detector.
// Assumes: samples are taken at states MID-1, MID and MID+1 of the counter.
// The vote is issued on the MID+1 tick and uses the line value seen then.
module rxv_voter #(
    parameter int OVS = 16,
    localparam int CW  = $clog2(OVS),
    localparam int MID = OVS / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic          line,
    output logic          vote_ok,
    output logic          vote
);
    import rxv_pkg::*;

    localparam logic [CW-1:0] S_LO  = CW'(MID - 1);
    localparam logic [CW-1:0] S_MID = CW'(MID);
    localparam logic [CW-1:0] S_HI  = CW'(MID + 1);

    logic samp_lo, samp_mid;

    // Hold the first two samples of the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_lo  <= 1'b1;
            samp_mid <= 1'b1;
        end else if (run && tick) begin
            if (cnt == S_LO)  samp_lo  <= line;
            if (cnt == S_MID) samp_mid <= line;
        end
    end

    // Decide the bit on the third sample.
    always_comb begin
        vote_ok = run && tick && (cnt == S_HI);
        vote    = maj3(samp_lo, samp_mid, line);
    end
endmodule

// File: rtl/rxv_frame.sv
// Module: frame controller, shift register and result registers.
// Assumes: votes arrive one per bit time. The shift register is preloaded
// with all ones, so the arrival of the start bit (0) at the top marks the last
// data bit, and the next vote is the stop bit.
module rxv_frame #(
    parameter int DATA_W = 8,
    localparam int SW = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              mp_mode,
    input  logic              flag_clr,
    input  logic              vote_ok,
    input  logic              vote,
    output logic              restart,
    output logic              run,
    output logic              accept,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_stop,
    output logic              rx_done
);
    import rxv_pkg::*;

    rx_state_t         state;
    logic              prev_line;
    logic [SW-1:0]     sreg;
    logic              empty;
    logic              last;
    logic [DATA_W-1:0] data_lsb;

    // Decode edge, start check and final shift.
    always_comb begin
        run     = (state == RX_SHIFT);
        restart = tick && (state == RX_HUNT) && prev_line && !line;
        empty   = &sreg;
        last    = vote_ok && !empty && !sreg[SW-1];
        accept  = last && !rx_done && (!mp_mode || vote);
        for (int i = 0; i < DATA_W; i++) begin
            data_lsb[i] = sreg[DATA_W-1-i];
        end
    end

    // Track the line level seen on the previous tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_line <= 1'b1;
        else if (tick) prev_line <= line;
    end

    // Frame sequencing and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_HUNT;
            sreg  <= '1;
        end else if (restart) begin
            state <= RX_SHIFT;
            sreg  <= '1;
        end else if (vote_ok) begin
            if (empty && vote) begin
                state <= RX_HUNT;
            end else if (last) begin
                state <= RX_HUNT;
                sreg  <= '1;
            end else begin
                sreg <= {sreg[SW-2:0], vote};
            end
        end
    end

    // Publish accepted frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rx_stop <= 1'b0;
        end else if (accept) begin
            rx_byte <= data_lsb;
            rx_stop <= vote;
        end
    end

    // Sticky done flag: set by accept, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_done <= 1'b0;
        else if (accept)   rx_done <= 1'b1;
        else if (flag_clr) rx_done <= 1'b0;
    end
endmodule

// File: rtl/uart_vote_rx.sv
// Module: top of the majority-vote serial frame receiver.
// Assumes: tick16 is a one-cycle pulse at OVS times the bit rate, the line
// idles high, and frames are start + DATA_W bits LSB first + stop.
module uart_vote_rx #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              mp_mode,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_stop,
    output logic              rx_done
);
    logic          line_s;
    logic [CW-1:0] cnt;
    logic          restart;
    logic          run;
    logic          vote_ok;
    logic          vote;
    logic          frame_accept;

    rxv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    rxv_bitcnt #(.OVS(OVS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .restart(restart),
        .run    (run),
        .cnt    (cnt)
    );

    rxv_voter #(.OVS(OVS)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .run    (run),
        .cnt    (cnt),
        .line   (line_s),
        .vote_ok(vote_ok),
        .vote   (vote)
    );

    rxv_frame #(.DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .line    (line_s),
        .mp_mode (mp_mode),
        .flag_clr(flag_clr),
        .vote_ok (vote_ok),
        .vote    (vote),
        .restart (restart),
        .run     (run),
        .accept  (frame_accept),
        .rx_byte (rx_byte),
        .rx_stop (rx_stop),
        .rx_done (rx_done)
    );
endmodule

// File: rtl/uart_vote_rx_chk.sv
// Module: property checker bound to uart_vote_rx.
// Assumes: frame_accept is the frame controller's internal publish strobe.
module uart_vote_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic              mp_mode,
    input logic              flag_clr,
    input logic              frame_accept,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_stop,
    input logic              rx_done
);
    // R1: reset values
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!rx_done && rx_byte == '0 && !rx_stop));

    // R6: a set flag blocks any update of the results
    a_r6_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !flag_clr) |=> (rx_done && $stable(rx_byte) && $stable(rx_stop)));

    // R8: clear takes effect on the next edge
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !frame_accept) |=> !rx_done);

    // R5: the flag rises only from an accepted frame
    a_r5_set_by_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(frame_accept));

    // R7: multiprocessor mode publishes only frames with a stop bit of 1
    a_r7_mp_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_done) && $past(mp_mode)) |-> rx_stop);

    // R10: no result movement without a tick
    a_r10_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && !flag_clr) |=> ($stable(rx_done) && $stable(rx_byte) && $stable(rx_stop)));
endmodule

bind uart_vote_rx uart_vote_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (tick16),
    .mp_mode     (mp_mode),
    .flag_clr    (flag_clr),
    .frame_accept(frame_accept),
    .rx_byte     (rx_byte),
    .rx_stop     (rx_stop),
    .rx_done     (rx_done)
);

// File: tb/uart_vote_rx_bench.sv
module uart_vote_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       mp_mode = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_stop;
    logic       rx_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_vote_rx u_uart_vote_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .mp_mode(mp_mode), .flag_clr(flag_clr),
        .rx_byte(rx_byte), .rx_stop(rx_stop), .rx_done(rx_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One tick slot: the line is set, allowed through the synchronizer, then ticked.
    task automatic slot(input logic v);
        @(negedge clk) rxd = v;
        @(negedge clk);
        @(negedge clk) tick16 = 1'b1;
        @(negedge clk) tick16 = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) slot(1'b1);
    endtask

    // Frame with optional corrupted tick offsets on the bits chosen by mask.
    task automatic send(input logic [7:0] d, input logic stp,
                        input logic [9:0] mask, input int fa, input int fb);
        for (int b = 0; b < 10; b++) begin
            logic bv;
            bv = (b == 0) ? 1'b0 : (b == 9) ? stp : d[b-1];
            for (int o = 0; o < 16; o++) begin
                logic v;
                v = bv;
                if (mask[b] && (o == fa || o == fb)) v = ~bv;
                slot(v);
            end
        end
        idle(4);
    endtask

    task automatic pulse_clear();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 done", rx_done, 0);
        check("R1 byte", rx_byte, 0);
        check("R1 stop", rx_stop, 0);
    endtask

    task automatic t_basic();
        send(8'hA5, 1'b1, 10'h0, -1, -1);
        check("R2 byte", rx_byte, 8'hA5);
        check("R5 stop", rx_stop, 1);
        check("R5 done", rx_done, 1);
    endtask

    task automatic t_full_drop();
        send(8'h3C, 1'b1, 10'h0, -1, -1);
        check("R6 byte kept", rx_byte, 8'hA5);
        check("R6 done", rx_done, 1);
        idle(3);
        check("R8 sticky", rx_done, 1);
        pulse_clear();
        check("R8 cleared", rx_done, 0);
        check("R8 byte kept", rx_byte, 8'hA5);
    endtask

    task automatic t_majority();
        send(8'h0F, 1'b1, 10'h3FF, 8, -1);
        check("R3 single bad sample", rx_byte, 8'h0F);
        check("R3 stop", rx_stop, 1);
        pulse_clear();
        send(8'h00, 1'b1, 10'b0000010000, 7, 8);
        check("R3 two bad samples", rx_byte, 8'h08);
        pulse_clear();
    endtask

    task automatic t_false_start();
        for (int i = 0; i < 8; i++) slot(1'b0);
        idle(12);
        check("R4 no flag", rx_done, 0);
        check("R4 byte kept", rx_byte, 8'h08);
        send(8'h5A, 1'b1, 10'h0, -1, -1);
        check("R9 after false start", rx_byte, 8'h5A);
        check("R9 done", rx_done, 1);
        pulse_clear();
    endtask

    task automatic t_mp_mode();
        mp_mode = 1'b1;
        send(8'h77, 1'b0, 10'h0, -1, -1);
        check("R7 mp drop done", rx_done, 0);
        check("R7 mp drop byte", rx_byte, 8'h5A);
        send(8'h81, 1'b1, 10'h0, -1, -1);
        check("R9 after drop", rx_byte, 8'h81);
        check("R7 mp accept", rx_done, 1);
        pulse_clear();
        mp_mode = 1'b0;
        send(8'hC3, 1'b0, 10'h0, -1, -1);
        check("R7 plain byte", rx_byte, 8'hC3);
        check("R7 plain stop", rx_stop, 0);
        check("R7 plain done", rx_done, 1);
        pulse_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_basic();
        t_full_drop();
        t_majority();
        t_false_start();
        t_mp_mode();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule